// File: doc/BRIEF.md
# Write-Once Byte Array with Pin-Selected Operating Modes

This block is a synthesizable behavioural model of an ultraviolet-erasable, one-time-writable byte memory. A small set of control pins selects the operating mode. These are an active-low chip select, an active-low output gate, a flag saying the programming supply is present, and a flag saying the identifier high voltage is on an address line. The modes are read, output disable, standby, program, verify, program inhibit and signature read. Programming can only clear bits. Only a bulk erase brings a bit back to one.

The block is clocked. Control, address and data pins are sampled on the rising edge. Read data, verify data and signature codes appear one cycle after they are requested. A high-impedance output is shown as `dout_en` low, and while `dout_en` is low, `dout` holds 00h. The depth is set by `ADDR_W`. It defaults to 10 to keep elaboration small, and a full 32K-word part uses 15.

The erase sequencer is a two-state machine:
- `ER_IDLE` moves to `ER_SWEEP` when `erase_req` is sampled high.
- `ER_SWEEP` writes FFh to one word per cycle, starting at word 0.
- After the last word, `ER_SWEEP` returns to `ER_IDLE`.

The mode decoder is combinational and has seven named results: `M_STANDBY`, `M_INHIBIT`, `M_OUT_DIS`, `M_READ`, `M_SIGNATURE`, `M_PROGRAM` and `M_VERIFY`.

Top module: `eprom_model`

## Requirements
- R1: The array holds 2^ADDR_W words of 8 bits, each selected by `addr`.
- R2: With `ce_n` high, `dout_en` is low one cycle later whatever `oe_n` is. With `vpp_hi` low this is standby. With `vpp_hi` high it is program inhibit, and no word changes in either case.
- R3: With `ce_n` low, `oe_n` high and `vpp_hi` low (output disable), `dout_en` is low one cycle later and no word changes.
- R4: With `ce_n`, `oe_n`, `vpp_hi` and `id_hi` all low (read), one cycle later `dout_en` is high and `dout` holds the word at `addr`.
- R5: With `vpp_hi` high, `ce_n` low and `oe_n` high (program), each cycle stores the AND of the addressed word and `din`. A bit at 0 never returns to 1 through programming.
- R6: With `vpp_hi` high and both `ce_n` and `oe_n` low (verify), one cycle later `dout_en` is high and `dout` holds the stored word. `id_hi` has no effect in this mode.
- R7: With read conditions and `id_hi` high (signature), one cycle later `dout` is 20h if `addr[0]` was 0 and 04h if it was 1.
- R8: When `erase_req` is sampled high while not busy, `erase_busy` is high for exactly 2^ADDR_W cycles starting the next cycle. After that, every word reads FFh.
- R9: While `erase_busy` is high, `dout_en` is low one cycle later, program writes are ignored and `erase_req` is ignored.
- R10: After reset, `dout_en` and `erase_busy` are low. Whenever `dout_en` is low, `dout` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply present |
| id_hi | input | 1 | Identifier voltage present on the address line |
| din | input | 8 | Data to program |
| erase_req | input | 1 | Start a bulk erase |
| dout | output | 8 | Read, verify or signature data |
| dout_en | output | 1 | Output driven (low means high impedance) |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The hardest case to reach is a program attempt on a word that the erase sweep has already passed, while the sweep is still running. If that write were accepted, the word would stay cleared and the fault would stay hidden until a later read. The bench starts an erase, waits a few cycles so that the sweep has passed word 0, and then drives a full program pulse of 00h at word 0. After the sweep ends, it reads word 0 back and expects FFh. It also repeats `erase_req` mid-sweep and checks that the busy window keeps its exact length.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] MFR_CODE = 8'h20;
    localparam logic [DATA_W-1:0] DEV_CODE = 8'h04;
    localparam logic [DATA_W-1:0] BLANK    = 8'hFF;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_INHIBIT,
        M_OUT_DIS,
        M_READ,
        M_SIGNATURE,
        M_PROGRAM,
        M_VERIFY
    } mode_t;

    typedef enum logic {
        ER_IDLE,
        ER_SWEEP
    } er_state_t;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    input  logic  id_hi,
    output mode_t mode
);
    always_comb begin
        unique case ({ce_n, vpp_hi, oe_n})
            3'b100, 3'b101: mode = M_STANDBY;
            3'b110, 3'b111: mode = M_INHIBIT;
            3'b001:         mode = M_OUT_DIS;
            3'b000:         mode = id_hi ? M_SIGNATURE : M_READ;
            3'b011:         mode = M_PROGRAM;
            default:        mode = M_VERIFY;
        endcase
    end
endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_req,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    er_state_t         state, state_nx;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ER_IDLE:  if (erase_req) state_nx = ER_SWEEP;
            ER_SWEEP: if (idx == LAST) state_nx = ER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ER_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == ER_SWEEP) idx <= idx + 1'b1;
            else                   idx <= '0;
        end
    end

    always_comb begin
        busy    = (state == ER_SWEEP);
        wr_en   = (state == ER_SWEEP);
        wr_addr = idx;
    end

    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx == LAST) |=> !busy); // R8
    AST_SWEEP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !busy) |=> (busy && idx == '0)); // R8
endmodule

// File: rtl/eprom_array.sv
module eprom_array
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              erase_we,
    input  logic [ADDR_W-1:0] erase_addr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (erase_we)     mem[erase_addr] <= BLANK;
        else if (prog_we) mem[addr] <= mem[addr] & din;
        rdata <= mem[addr];
    end

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk)
        (prog_we && !erase_we) |=> ((mem[$past(addr)] & ~$past(mem[addr])) == '0)); // R5
endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic [7:0]        din,
    input  logic              erase_req,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              erase_busy
);
    mode_t             mode;
    logic              prog_we, erase_we, sig_q, a0_q, en_q;
    logic [ADDR_W-1:0] erase_addr;
    logic [DATA_W-1:0] rdata;

    eprom_mode_dec i_dec (
        .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .id_hi(id_hi), .mode(mode)
    );

    eprom_erase_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .erase_req(erase_req),
        .busy(erase_busy), .wr_en(erase_we), .wr_addr(erase_addr)
    );

    assign prog_we = (mode == M_PROGRAM) && !erase_busy;

    eprom_array #(.ADDR_W(ADDR_W)) i_arr (
        .clk(clk), .prog_we(prog_we), .addr(addr), .din(din),
        .erase_we(erase_we), .erase_addr(erase_addr), .rdata(rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sig_q <= 1'b0;
            a0_q  <= 1'b0;
        end else begin
            en_q  <= !erase_busy &&
                     (mode == M_READ || mode == M_VERIFY || mode == M_SIGNATURE);
            sig_q <= (mode == M_SIGNATURE);
            a0_q  <= addr[0];
        end
    end

    always_comb begin
        dout_en = en_q;
        if (!en_q)      dout = '0;
        else if (sig_q) dout = a0_q ? DEV_CODE : MFR_CODE;
        else            dout = rdata;
    end

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en); // R2
    AST_GATE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> !dout_en); // R3
    AST_SIG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi && id_hi && !erase_busy)
        |=> (dout == ($past(addr[0]) ? 8'h04 : 8'h20))); // R7
    AST_BUSY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |=> !dout_en); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00)); // R10
endmodule

// File: tb/test_eprom_model.sv
`timescale 1ns/1ps
module test_eprom_model;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0;
    logic [7:0]    din = 8'hFF;
    logic          erase_req = 1'b0;
    logic [7:0]    dout;
    logic          dout_en, erase_busy;
    int            errors = 0, checks = 0;

    always #2 clk = ~clk;

    eprom_model #(.ADDR_W(AW)) i_eprom_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_hi(vpp_hi), .id_hi(id_hi), .din(din), .erase_req(erase_req),
        .dout(dout), .dout_en(dout_en), .erase_busy(erase_busy)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_hi = 1'b0; erase_req = 1'b0;
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; id_hi = 1'b0;
        tick();
        check(req, {dout_en, dout}, {1'b1, exp});
        idle();
    endtask

    task automatic program_word(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; din = d; vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        tick();
        ce_n = 1'b1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        check("R10 reset outputs", {dout_en, dout}, 9'h000);
        check("R10 reset busy", {8'h00, erase_busy}, 9'h000);
    endtask

    task automatic t_erase();
        int n = 0;
        erase_req = 1'b1;
        tick();
        erase_req = 1'b0;
        while (erase_busy && n < DEPTH + 10) begin
            n++;
            tick();
        end
        check("R8 busy length", 9'(n), 9'(DEPTH));
        read_expect('0, 8'hFF, "R8 blank word 0");
        read_expect(AW'(DEPTH - 1), 8'hFF, "R8 blank last word");
        read_expect(AW'(333), 8'hFF, "R1 R8 blank mid word");
    endtask

    task automatic t_program_and();
        program_word(AW'(5), 8'hA5);
        read_expect(AW'(5), 8'hA5, "R5 first program");
        program_word(AW'(5), 8'h3C);
        read_expect(AW'(5), 8'h24, "R5 AND with existing");
        program_word(AW'(5), 8'hFF);
        read_expect(AW'(5), 8'h24, "R5 no zero to one");
        program_word(AW'(6), 8'h5A);
        read_expect(AW'(6), 8'h5A, "R1 R4 distinct word");
        read_expect(AW'(5), 8'h24, "R1 neighbour kept");
    endtask

    task automatic t_hiz_modes();
        addr = AW'(6); din = 8'h00;
        ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b0;
        tick();
        check("R2 standby oe low", {dout_en, dout}, 9'h000);
        ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b1;
        tick();
        check("R2 inhibit hiz", {dout_en, dout}, 9'h000);
        ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b0;
        tick();
        check("R3 output disable", {dout_en, dout}, 9'h000);
        idle();
        read_expect(AW'(6), 8'h5A, "R2 R3 word untouched");
    endtask

    task automatic t_verify();
        addr = AW'(5); ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b1; id_hi = 1'b1;
        tick();
        check("R6 verify ignores id", {dout_en, dout}, {1'b1, 8'h24});
        idle();
    endtask

    task automatic t_signature();
        addr = AW'(6); ce_n = 1'b0; oe_n = 1'b0; id_hi = 1'b1;
        tick();
        check("R7 manufacturer 20h", {dout_en, dout}, 9'h120);
        addr = AW'(7);
        tick();
        check("R7 device 04h", {dout_en, dout}, 9'h104);
        idle();
    endtask

    task automatic t_program_during_erase();
        int n = 0;
        program_word('0, 8'h00);
        read_expect('0, 8'h00, "R5 word 0 cleared");
        erase_req = 1'b1;
        tick();
        erase_req = 1'b0;
        tick(); tick(); tick();
        program_word('0, 8'h00);
        n = 5;
        addr = AW'(6); ce_n = 1'b0; oe_n = 1'b0;
        erase_req = 1'b1;
        tick();
        check("R9 no output while busy", {dout_en, dout}, 9'h000);
        idle();
        n++;
        while (erase_busy && n < DEPTH + 10) begin
            n++;
            tick();
        end
        check("R9 repeat request ignored", 9'(n), 9'(DEPTH));
        read_expect('0, 8'hFF, "R9 program ignored while busy");
        read_expect(AW'(5), 8'hFF, "R8 second erase");
    endtask

    initial begin
        #5000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_erase();
        t_program_and();
        t_hiz_modes();
        t_verify();
        t_signature();
        t_program_during_erase();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule